// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running 63-bit tick count next to a 63-bit compare limit. The top bit of each 64-bit software word is a control flag held apart from the value. On the count side it is a flag that marks the counter as not readable by unprivileged code, and reads return it in bit 63. On the limit side it turns the interrupt off. When an armed limit is reached, the block sets one bit of a soft-interrupt vector and gives a one-clock wake pulse to the core.

Software loads the count and reads it back through a plain write/read port. It programs the limit through a write port and acknowledges the interrupt by clearing soft-interrupt bits. One design serves the tick, system-tick and hypervisor-tick timers. A parameter picks the soft-interrupt bit that an instance drives. A second parameter sets how many clocks make one tick, so the count can advance at a fixed 100 MHz rate from a faster clock. The default of one clock per tick fits a 100 MHz clock.

Top module: `tick_cmp_timer`

## Requirements
- R1: During and right after reset, the count reads 64'h8000_0000_0000_0000: the value is zero and the protect flag is set. The limit is disabled and disarmed, `softint_o` is zero and `wake_o` is low.
- R2: `cnt_rdata_o` shows the 63-bit count in bits 62:0. Bit 63 is 1 exactly when the protect flag is set.
- R3: A count write loads bits 62:0 as the new value and bit 63 as the protect flag. It takes priority over the advance in the same clock and restarts the tick phase.
- R4: The count grows by one every `TICK_DIV` clocks. It wraps from 63'h7FFF_FFFF_FFFF_FFFF to zero and leaves the protect flag unchanged.
- R5: A limit write with bit 63 clear and a nonzero value in bits 62:0 arms the compare. In the clock after the count first reaches the limit, bit `SOFTINT_BIT` of `softint_o` becomes 1, and `wake_o` is high for that one clock.
- R6: A limit write with bit 63 set fires no interrupt for that limit.
- R7: A limit write whose bits 62:0 are zero cancels any armed compare, and no interrupt fires.
- R8: An enabled limit at or below the current count fires in the clock after the limit write. The match is not lost.
- R9: A limit fires at most once. After firing, the compare stays disarmed until the next limit write.
- R10: Soft-interrupt bits stay set until a clock in which the matching bit of `softint_clr_i` is 1. A new match in that same clock takes priority over the clear.
- R11: Only bit `SOFTINT_BIT` of `softint_o` is ever set by this instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | WORD_W | Count write data: bit 63 protect flag, bits 62:0 value |
| cnt_rdata_o | output | WORD_W | Count read data: protect flag in bit 63 |
| lim_we_i | input | 1 | Limit write strobe |
| lim_wdata_i | input | WORD_W | Limit write data: bit 63 disable, bits 62:0 compare value |
| softint_clr_i | input | SOFTINT_W | Clear mask for the soft-interrupt bits |
| softint_o | output | SOFTINT_W | Soft-interrupt vector |
| wake_o | output | 1 | One-clock wake pulse on a match |

## Verification
The bench builds one instance with `TICK_DIV` = 1 and `SOFTINT_BIT` = 0. In that instance every clock is a tick, so match timing, wrap-around, past limits, zero limits and disabled limits can all be checked at exact clocks. A second instance uses `TICK_DIV` = 3 and `SOFTINT_BIT` = 14. It brings within reach the prescaled advance, the phase restart on a count write, and the routing of a match to a bit other than zero.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic {
    ARM_OFF = 1'b0,
    ARM_ON  = 1'b1
  } arm_state_e;

  function automatic int unsigned phase_width(int unsigned div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned TICK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  import tick_timer_pkg::*;

  localparam int unsigned PH_W = phase_width(TICK_DIV);

  generate
    if (TICK_DIV <= 1) begin : g_every_clk
      logic unused_ins;
      assign unused_ins = ^{clk_i, rst_ni, restart_i};
      assign tick_o     = 1'b1;
    end else begin : g_divided
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICK_DIV - 1);
      logic [PH_W-1:0] ph_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              ph_q <= '0;
        else if (restart_i)       ph_q <= '0;
        else if (ph_q == PH_LAST) ph_q <= '0;
        else                      ph_q <= ph_q + PH_W'(1);
      end

      assign tick_o = (ph_q == PH_LAST) && !restart_i;
    end
  endgenerate

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned VAL_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             we_i,
  input  logic [VAL_W:0]   wdata_i,
  output logic [VAL_W-1:0] val_o,
  output logic             npt_o
);

  logic [VAL_W-1:0] val_q;
  logic             npt_q;

  // write wins over advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      npt_q <= 1'b1;
    end else if (we_i) begin
      val_q <= wdata_i[VAL_W-1:0];
      npt_q <= wdata_i[VAL_W];
    end else if (tick_i) begin
      val_q <= val_q + VAL_W'(1);
    end
  end

  assign val_o = val_q;
  assign npt_o = npt_q;

endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int unsigned VAL_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim_we_i,
  input  logic [VAL_W:0]   lim_wdata_i,
  input  logic [VAL_W-1:0] count_i,
  output logic             fire_o,
  output logic             armed_o
);
  import tick_timer_pkg::*;

  logic [VAL_W-1:0] lim_q;
  logic             dis_q;
  arm_state_e       arm_q, arm_d;
  logic             wr_zero;

  assign wr_zero = (lim_wdata_i[VAL_W-1:0] == '0);

  // >= keeps a limit already behind the count from being lost
  assign fire_o  = (arm_q == ARM_ON) && !dis_q && (count_i >= lim_q);
  assign armed_o = (arm_q == ARM_ON);

  always_comb begin
    arm_d = arm_q;
    if (lim_we_i) begin
      arm_d = (!wr_zero && !lim_wdata_i[VAL_W]) ? ARM_ON : ARM_OFF;
    end else if (fire_o) begin
      arm_d = ARM_OFF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      dis_q <= 1'b1;
      arm_q <= ARM_OFF;
    end else begin
      arm_q <= arm_d;
      if (lim_we_i) begin
        lim_q <= lim_wdata_i[VAL_W-1:0];
        dis_q <= lim_wdata_i[VAL_W];
      end
    end
  end

endmodule

// File: rtl/tick_softint.sv
module tick_softint #(
  parameter int unsigned SOFTINT_W   = 16,
  parameter int unsigned SOFTINT_BIT = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [SOFTINT_W-1:0] clr_i,
  output logic [SOFTINT_W-1:0] softint_o,
  output logic                 wake_o
);

  localparam logic [SOFTINT_W-1:0] SET_MASK = SOFTINT_W'(1) << SOFTINT_BIT;

  logic [SOFTINT_W-1:0] si_q;
  logic                 wake_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      si_q   <= '0;
      wake_q <= 1'b0;
    end else begin
      si_q   <= (si_q & ~clr_i) | (set_i ? SET_MASK : '0);
      wake_q <= set_i;
    end
  end

  assign softint_o = si_q;
  assign wake_o    = wake_q;

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int unsigned WORD_W      = 64,
  parameter int unsigned SOFTINT_W   = 16,
  parameter int unsigned SOFTINT_BIT = 0,
  parameter int unsigned TICK_DIV    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cnt_we_i,
  input  logic [WORD_W-1:0]    cnt_wdata_i,
  output logic [WORD_W-1:0]    cnt_rdata_o,
  input  logic                 lim_we_i,
  input  logic [WORD_W-1:0]    lim_wdata_i,
  input  logic [SOFTINT_W-1:0] softint_clr_i,
  output logic [SOFTINT_W-1:0] softint_o,
  output logic                 wake_o
);

  localparam int unsigned VAL_W = WORD_W - 1;

  logic             tick_en;
  logic [VAL_W-1:0] count;
  logic             npt;
  logic             fire;
  logic             armed;

  tick_prescaler #(.TICK_DIV(TICK_DIV)) i_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (cnt_we_i),
    .tick_o    (tick_en)
  );

  tick_counter #(.VAL_W(VAL_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_en),
    .we_i    (cnt_we_i),
    .wdata_i (cnt_wdata_i),
    .val_o   (count),
    .npt_o   (npt)
  );

  tick_compare #(.VAL_W(VAL_W)) i_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lim_we_i    (lim_we_i),
    .lim_wdata_i (lim_wdata_i),
    .count_i     (count),
    .fire_o      (fire),
    .armed_o     (armed)
  );

  tick_softint #(.SOFTINT_W(SOFTINT_W), .SOFTINT_BIT(SOFTINT_BIT)) i_si (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (fire),
    .clr_i     (softint_clr_i),
    .softint_o (softint_o),
    .wake_o    (wake_o)
  );

  assign cnt_rdata_o = {npt, count};

endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
  parameter int unsigned WORD_W      = 64,
  parameter int unsigned SOFTINT_W   = 16,
  parameter int unsigned SOFTINT_BIT = 0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cnt_we_i,
  input logic [WORD_W-1:0]    cnt_rdata_o,
  input logic                 lim_we_i,
  input logic [WORD_W-1:0]    lim_wdata_i,
  input logic [SOFTINT_W-1:0] softint_o,
  input logic                 wake_o,
  input logic                 armed_i
);

  localparam int unsigned VAL_W = WORD_W - 1;
  localparam logic [SOFTINT_W-1:0] OWN_MASK = SOFTINT_W'(1) << SOFTINT_BIT;

  assert_flag_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cnt_we_i) |-> $stable(cnt_rdata_o[VAL_W]));

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cnt_we_i) |-> (cnt_rdata_o[VAL_W-1:0] == $past(cnt_rdata_o[VAL_W-1:0]) ||
                          cnt_rdata_o[VAL_W-1:0] == $past(cnt_rdata_o[VAL_W-1:0]) + VAL_W'(1)));

  assert_wake_sets_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> softint_o[SOFTINT_BIT]);

  assert_disabled_disarms_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_we_i && lim_wdata_i[VAL_W] |=> !armed_i);

  assert_zero_disarms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_we_i && (lim_wdata_i[VAL_W-1:0] == '0) |=> !armed_i);

  assert_wake_needs_arm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(armed_i));

  assert_disarm_after_fire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o && !$past(lim_we_i) |-> !armed_i);

  assert_own_bit_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (softint_o & ~OWN_MASK) == '0);

endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(
  .WORD_W      (WORD_W),
  .SOFTINT_W   (SOFTINT_W),
  .SOFTINT_BIT (SOFTINT_BIT)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_we_i    (cnt_we_i),
  .cnt_rdata_o (cnt_rdata_o),
  .lim_we_i    (lim_we_i),
  .lim_wdata_i (lim_wdata_i),
  .softint_o   (softint_o),
  .wake_o      (wake_o),
  .armed_i     (armed)
);

// File: tb/test_tick_cmp_timer.sv
module test_tick_cmp_timer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        a_cwe = 1'b0, a_lwe = 1'b0;
  logic [63:0] a_cwd = '0, a_lwd = '0;
  logic [15:0] a_clr = '0;
  logic [63:0] a_rd;
  logic [15:0] a_si;
  logic        a_wake;

  logic        b_cwe = 1'b0, b_lwe = 1'b0;
  logic [63:0] b_cwd = '0, b_lwd = '0;
  logic [15:0] b_clr = '0;
  logic [63:0] b_rd;
  logic [15:0] b_si;
  logic        b_wake;

  tick_cmp_timer i_tick_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n),
    .cnt_we_i(a_cwe), .cnt_wdata_i(a_cwd), .cnt_rdata_o(a_rd),
    .lim_we_i(a_lwe), .lim_wdata_i(a_lwd),
    .softint_clr_i(a_clr), .softint_o(a_si), .wake_o(a_wake)
  );

  tick_cmp_timer #(.TICK_DIV(3), .SOFTINT_BIT(14)) i_tick_cmp_timer_div (
    .clk_i(clk), .rst_ni(rst_n),
    .cnt_we_i(b_cwe), .cnt_wdata_i(b_cwd), .cnt_rdata_o(b_rd),
    .lim_we_i(b_lwe), .lim_wdata_i(b_lwd),
    .softint_clr_i(b_clr), .softint_o(b_si), .wake_o(b_wake)
  );

  int n_chk = 0;
  int n_fail = 0;
  int wakes;
  bit done = 0;

  // count-write vectors: data written, clocks waited, expected read
  localparam logic [63:0] VEC_W [4] = '{64'h8000_0000_0000_0000, 64'h0000_0000_0000_0010,
                                       64'h7FFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam int          VEC_N [4] = '{3, 4, 3, 1};
  localparam logic [63:0] VEC_X [4] = '{64'h8000_0000_0000_0003, 64'h0000_0000_0000_0014,
                                       64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (a_wake) wakes++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    @(negedge clk);
    check("R1 count", a_rd, 64'h8000_0000_0000_0000);
    check("R1 softint", {48'd0, a_si}, 64'd0);
    check("R1 wake", {63'd0, a_wake}, 64'd0);
    rst_n = 1'b1;
    wakes = 0;
    run(6);
    check("R1 disabled at reset", {48'd0, a_si}, 64'd0);
    check("R1 no wake", 64'(wakes), 64'd0);

    // R2 R3 R4: vector walk
    for (int v = 0; v < 4; v++) begin
      a_cwe = 1'b1; a_cwd = VEC_W[v];
      step();
      a_cwe = 1'b0;
      run(VEC_N[v]);
      check("R2 R3 R4 read", a_rd, VEC_X[v]);
    end

    // R5: normal match at limit 10
    a_cwe = 1'b1; a_cwd = 64'd0; a_lwe = 1'b1; a_lwd = 64'd10;
    step();
    a_cwe = 1'b0; a_lwe = 1'b0;
    run(10);
    check("R5 count at limit", a_rd, 64'd10);
    check("R5 not yet set", {48'd0, a_si}, 64'd0);
    step();
    check("R5 bit set", {48'd0, a_si}, 64'd1);
    check("R5 wake", {63'd0, a_wake}, 64'd1);
    step();
    check("R5 wake one clock", {63'd0, a_wake}, 64'd0);
    wakes = 0;
    run(20);
    check("R9 fires once", 64'(wakes), 64'd0);
    check("R10 sticky", {48'd0, a_si}, 64'd1);
    a_clr = 16'h0001;
    step();
    a_clr = 16'h0000;
    check("R10 cleared", {48'd0, a_si}, 64'd0);

    // R6: disabled limit
    a_cwe = 1'b1; a_cwd = 64'd0; a_lwe = 1'b1; a_lwd = 64'h8000_0000_0000_000A;
    step();
    a_cwe = 1'b0; a_lwe = 1'b0;
    wakes = 0;
    run(15);
    check("R6 no wake", 64'(wakes), 64'd0);
    check("R6 no softint", {48'd0, a_si}, 64'd0);

    // R7: zero limit cancels armed compare
    a_cwe = 1'b1; a_cwd = 64'd0; a_lwe = 1'b1; a_lwd = 64'd20;
    step();
    a_cwe = 1'b0; a_lwe = 1'b0;
    run(5);
    a_lwe = 1'b1; a_lwd = 64'd0;
    step();
    a_lwe = 1'b0;
    wakes = 0;
    run(30);
    check("R7 no wake", 64'(wakes), 64'd0);
    check("R7 no softint", {48'd0, a_si}, 64'd0);

    // R8: limit already behind the count
    a_cwe = 1'b1; a_cwd = 64'd100;
    step();
    a_cwe = 1'b0; a_lwe = 1'b1; a_lwd = 64'd50;
    step();
    a_lwe = 1'b0;
    check("R8 not before write", {48'd0, a_si}, 64'd0);
    step();
    check("R8 fires next clock", {48'd0, a_si}, 64'd1);
    check("R8 wake", {63'd0, a_wake}, 64'd1);

    // R10: new match beats same-cycle clear
    a_cwe = 1'b1; a_cwd = 64'd200; a_lwe = 1'b1; a_lwd = 64'd201;
    step();
    a_cwe = 1'b0; a_lwe = 1'b0;
    step();
    a_clr = 16'h0001;
    step();
    a_clr = 16'h0000;
    check("R10 set wins over clear", {48'd0, a_si}, 64'd1);

    // R4 R11: prescaled instance, bit 14
    b_cwe = 1'b1; b_cwd = 64'd0; b_lwe = 1'b1; b_lwd = 64'd2;
    step();
    b_cwe = 1'b0; b_lwe = 1'b0;
    run(2);
    check("R4 held between ticks", b_rd, 64'd0);
    step();
    check("R4 one tick per three clocks", b_rd, 64'd1);
    run(3);
    check("R4 second tick", b_rd, 64'd2);
    check("R11 not yet", {48'd0, b_si}, 64'd0);
    step();
    check("R11 bit 14 only", {48'd0, b_si}, 64'h4000);
    check("R11 wake", {63'd0, b_wake}, 64'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule